// File: doc/BRIEF.md
# DMA Channel Request/Acknowledge Sequencer

This block is one DMA channel. It waits for a transfer request, runs one dual-address unit at a time over a simple single-cycle bus master port, and pulses an acknowledge strobe toward an external requester. Each unit reads a byte or a 16-bit word from the source address and writes it to the destination address on the next cycle. The channel then steps both addresses and decrements a transfer counter. When the counter reaches zero the channel raises an end flag and, if enabled, an interrupt.

Software programs the channel through four registers chosen by `reg_sel`: control (0), source address (1), destination address (2) and transfer count (3). A request can come from an active-low external pin, from a timer line, from an A/D-done line, or from an auto source that is always asserted. The external pin passes through a two-flop synchroniser. It is detected either as a low level or as a falling edge. The acknowledge strobe can be placed in the read cycle or the write cycle, and its polarity can be chosen. Instances built with `EXT_CAPABLE = 0` ignore the external pin and the three external-signalling bits.

The sequencer has three states: `ST_IDLE`, `ST_READ` and `ST_WRITE`. The transitions are:
- IDLE to READ (start): the channel is runnable and the selected request is present.
- READ to WRITE (always).
- WRITE to READ (burst continue): burst mode is set, enable is still 1 and this was not the last unit.
- WRITE to IDLE (release): cycle-steal mode, enable cleared, or last unit.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset every control bit is 0 and `bus_req`, `bus_rd`, `bus_wr`, `ack` and `irq` are low. The control register layout is: bit0 enable, bit1 word size, bit2 burst, bit3 interrupt enable, bit4 end flag, bit5 edge detect, bit6 acknowledge active-low, bit7 acknowledge in write cycle, bits 11:8 request source. Bits 15:12 read as 0.
- R2: Source code 0000 selects the external pin, 1011 the timer line, 1100 auto-request and 1101 the A/D line. Any other code starts nothing. A control write that carries 1110 or 1111 leaves the source field unchanged but updates the other bits.
- R3: A unit is one `bus_rd` cycle at the source address followed by one `bus_wr` cycle at the destination address. The write data equals the data read. Both addresses then advance by 1 (byte) or 2 (word), and the count drops by 1.
- R4: In cycle-steal mode `bus_req` goes low for at least one cycle after every unit. In burst mode `bus_req` stays high from the first read until the last write.
- R5: The external request is synchronised by two flops. With edge detect 0, a low level requests a unit each time the channel is idle. With edge detect 1, each falling edge grants exactly one unit, however long the pin stays low.
- R6: `ack` is asserted during `bus_rd` when bit7 is 0 and during `bus_wr` when bit7 is 1. This applies only to the external source. Asserted means high when bit6 is 0 and low when bit6 is 1. At all other times `ack` sits at its inactive level.
- R7: With `EXT_CAPABLE = 0`, bits 5 to 7 read back as 0 whatever was written, `ack` stays low, and the external pin never starts a unit.
- R8: The end flag sets when the unit that brings the count from 1 to 0 completes. A control write with bit4 = 0 clears it only if the last control access before it was a read that returned the flag as 1. Otherwise the write, and any write of 1, leave the flag unchanged.
- R9: `irq` is high exactly while the end flag and the interrupt-enable bit are both 1.
- R10: A unit starts only while enable = 1, the end flag = 0 and the count is non-zero. Clearing enable during a burst lets the current unit finish and then returns to idle with the remaining count kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 2 | Register select: 0 control, 1 source, 2 destination, 3 count |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms end-flag clearing) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| ext_req_n | input | 1 | External transfer request, active low, asynchronous |
| timer_req | input | 1 | Timer compare/capture request |
| adc_req | input | 1 | A/D conversion-done request |
| bus_req | output | 1 | Channel holds the bus |
| bus_rd | output | 1 | Read cycle at `bus_addr` |
| bus_wr | output | 1 | Write cycle at `bus_addr` |
| bus_word | output | 1 | Unit size: 1 word, 0 byte |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid during `bus_rd` |
| ack | output | 1 | Acknowledge strobe to the external requester |
| irq | output | 1 | End-of-transfer interrupt |

## Verification
The bench goes after the end-flag handshake. A write of 0 without a prior read must leave the flag set. A design that forgot the read condition would drop the interrupt early, and one that let a write of 1 set the flag would raise a false interrupt. In edge mode, a pin held low for many cycles must cost exactly one unit; a design that detected the level would drain the counter. Clearing enable during a burst must leave a non-zero count and an idle bus, and a design that checked enable only at the start would run to the end. The acknowledge phase and polarity are compared every cycle in both cycle positions. The reserved-source write and the non-capable instance check that masked fields keep or zero their values.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } dma_state_e;

    localparam logic [3:0] SRC_EXT   = 4'b0000;
    localparam logic [3:0] SRC_TIMER = 4'b1011;
    localparam logic [3:0] SRC_AUTO  = 4'b1100;
    localparam logic [3:0] SRC_ADC   = 4'b1101;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_SRC  = 2'd1;
    localparam logic [1:0] REG_DST  = 2'd2;
    localparam logic [1:0] REG_CNT  = 2'd3;

    typedef struct packed {
        logic [3:0] src;
        logic       ack_on_wr;
        logic       ack_low;
        logic       edge_det;
        logic       done;
        logic       irq_en;
        logic       burst;
        logic       word;
        logic       en;
    } ctrl_t;

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic consume,
    output logic level_req,
    output logic edge_pend
);
    logic [STAGES-1:0] chain;
    logic              last;
    logic              fall;

    assign fall      = last & ~chain[STAGES-1];
    assign level_req = ~chain[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain     <= '1;
            last      <= 1'b1;
            edge_pend <= 1'b0;
        end else begin
            chain     <= {chain[STAGES-2:0], pin_n};
            last      <= chain[STAGES-1];
            edge_pend <= edge_mode & (fall | (edge_pend & ~consume));
        end
    end

    // R5: a pending edge can only appear while edge detection is selected
    p_pend_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(edge_pend) |-> $past(edge_mode));

endmodule

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
    import dma_chan_pkg::*;
#(
    parameter bit EXT_CAPABLE = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [11:0] wdata,
    input  logic        set_done,
    output ctrl_t       ctrl
);
    ctrl_t w;
    logic  armed;

    assign w = ctrl_t'(wdata);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl  <= '0;
            armed <= 1'b0;
        end else begin
            if (wr_en) begin
                if (w.src[3:1] != 3'b111) ctrl.src <= w.src;
                ctrl.ack_on_wr <= EXT_CAPABLE & w.ack_on_wr;
                ctrl.ack_low   <= EXT_CAPABLE & w.ack_low;
                ctrl.edge_det  <= EXT_CAPABLE & w.edge_det;
                ctrl.irq_en    <= w.irq_en;
                ctrl.burst     <= w.burst;
                ctrl.word      <= w.word;
                ctrl.en        <= w.en;
            end
            if (set_done)
                ctrl.done <= 1'b1;
            else if (wr_en && armed && !w.done)
                ctrl.done <= 1'b0;
            if (wr_en)
                armed <= 1'b0;
            else if (rd_en && ctrl.done)
                armed <= 1'b1;
        end
    end

    p_src_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.src[3:1] != 3'b111);

    p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl.done) |-> ($past(armed) && $past(wr_en)));

    p_nocap_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !EXT_CAPABLE |-> !(ctrl.ack_on_wr | ctrl.ack_low | ctrl.edge_det));

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dma_chan_pkg::*;
#(
    parameter int AW          = 16,
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2,
    parameter bit EXT_CAPABLE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    reg_sel,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    input  logic          ext_req_n,
    input  logic          timer_req,
    input  logic          adc_req,
    output logic          bus_req,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          bus_word,
    output logic [AW-1:0] bus_addr,
    output logic [15:0]   bus_wdata,
    input  logic [15:0]   bus_rdata,
    output logic          ack,
    output logic          irq
);
    localparam logic [AW-1:0] STEP_BYTE = AW'(1);
    localparam logic [AW-1:0] STEP_WORD = AW'(2);
    localparam logic [CW-1:0] CNT_ONE   = CW'(1);

    dma_state_e     state, state_nx;
    ctrl_t          ctrl;
    logic [AW-1:0]  src_q, dst_q, step;
    logic [CW-1:0]  cnt_q;
    logic [15:0]    data_q;
    logic           level_req, edge_pend;
    logic           ext_sel, runnable, req_hit, last_unit, start, set_done;

    assign ext_sel   = EXT_CAPABLE && (ctrl.src == SRC_EXT);
    assign runnable  = ctrl.en && !ctrl.done && (cnt_q != '0);
    assign last_unit = (cnt_q == CNT_ONE);
    assign step      = ctrl.word ? STEP_WORD : STEP_BYTE;
    assign start     = (state == ST_IDLE) && (state_nx == ST_READ);
    assign set_done  = (state == ST_WRITE) && last_unit;

    dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (ext_req_n),
        .edge_mode (ext_sel && ctrl.edge_det),
        .consume   (start),
        .level_req (level_req),
        .edge_pend (edge_pend)
    );

    dma_ctrl_reg #(.EXT_CAPABLE(EXT_CAPABLE)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr && (reg_sel == REG_CTRL)),
        .rd_en    (reg_rd && (reg_sel == REG_CTRL)),
        .wdata    (reg_wdata[11:0]),
        .set_done (set_done),
        .ctrl     (ctrl)
    );

    always_comb begin
        case (ctrl.src)
            SRC_EXT:   req_hit = EXT_CAPABLE && (ctrl.edge_det ? edge_pend : level_req);
            SRC_TIMER: req_hit = timer_req;
            SRC_AUTO:  req_hit = 1'b1;
            SRC_ADC:   req_hit = adc_req;
            default:   req_hit = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (runnable && req_hit) state_nx = ST_READ;
            ST_READ:  state_nx = ST_WRITE;
            ST_WRITE: begin
                if (!last_unit && ctrl.burst && ctrl.en) state_nx = ST_READ;
                else                                     state_nx = ST_IDLE;
            end
            default:  state_nx = ST_IDLE;
        endcase
    end

    // address, count and data holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            data_q <= '0;
        end else begin
            if (state == ST_READ) data_q <= bus_rdata;
            if (state == ST_WRITE) begin
                src_q <= src_q + step;
                dst_q <= dst_q + step;
                cnt_q <= cnt_q - CNT_ONE;
            end else if (reg_wr) begin
                case (reg_sel)
                    REG_SRC: src_q <= AW'(reg_wdata);
                    REG_DST: dst_q <= AW'(reg_wdata);
                    REG_CNT: cnt_q <= CW'(reg_wdata);
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        bus_req   = (state != ST_IDLE);
        bus_rd    = (state == ST_READ);
        bus_wr    = (state == ST_WRITE);
        bus_word  = ctrl.word;
        bus_addr  = (state == ST_WRITE) ? dst_q : src_q;
        bus_wdata = data_q;
        ack       = ctrl.ack_low ^ (ext_sel &&
                    (ctrl.ack_on_wr ? (state == ST_WRITE) : (state == ST_READ)));
        irq       = ctrl.done && ctrl.irq_en;
        case (reg_sel)
            REG_CTRL: reg_rdata = {4'b0000, ctrl};
            REG_SRC:  reg_rdata = 16'(src_q);
            REG_DST:  reg_rdata = 16'(dst_q);
            default:  reg_rdata = 16'(cnt_q);
        endcase
    end

    p_rd_then_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_wr);

    p_count_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> (cnt_q == $past(cnt_q) - CNT_ONE));

    p_steal_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !ctrl.burst) |=> !bus_req);

    p_ack_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> (ack == ctrl.ack_low));

    p_nocap_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !EXT_CAPABLE |-> !ack);

    p_done_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl.done) |-> ($past(bus_wr) && $past(cnt_q) == CNT_ONE));

    p_start_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(ctrl.en && !ctrl.done));

endmodule

// File: tb/dma_chan_ctl_bench.sv
module dma_chan_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata, rdata_nc;
    logic        ext_req_n = 1'b1, timer_req = 1'b0, adc_req = 1'b0;
    logic        bus_req, bus_rd, bus_wr, bus_word, ack, irq;
    logic [15:0] bus_addr, bus_wdata, bus_rdata;
    logic        nc_req, nc_rd, nc_wr, nc_word, nc_ack, nc_irq;
    logic [15:0] nc_addr, nc_wdata;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;

    always #10 clk = ~clk;

    assign bus_rdata = bus_addr ^ 16'h5A3C;

    dma_chan_ctl u_dma_chan_ctl (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_req_n(ext_req_n),
        .timer_req(timer_req), .adc_req(adc_req), .bus_req(bus_req), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ack(ack), .irq(irq));

    dma_chan_ctl #(.EXT_CAPABLE(1'b0)) u_dma_chan_ctl_nc (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(rdata_nc), .ext_req_n(ext_req_n),
        .timer_req(timer_req), .adc_req(adc_req), .bus_req(nc_req), .bus_rd(nc_rd),
        .bus_wr(nc_wr), .bus_word(nc_word), .bus_addr(nc_addr), .bus_wdata(nc_wdata),
        .bus_rdata(16'h0000), .ack(nc_ack), .irq(nc_irq));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int          ms = 0;
    logic [15:0] msrc = 0, mdst = 0, mcnt = 0, mdata = 0;
    logic [3:0]  mrs = 0;
    bit mam, mal, mds, mdone, mie, mtm, mts, men, marmed;
    bit s1 = 1, s2 = 1, s3 = 1, mpend = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; msrc = 0; mdst = 0; mcnt = 0; mdata = 0; mrs = 0;
            {mam, mal, mds, mdone, mie, mtm, mts, men, marmed} = '0;
            s1 = 1; s2 = 1; s3 = 1; mpend = 0;
        end else begin : step_blk
            logic [15:0] stp;
            bit hit, start, setd, fall, odone, cwr, crd, ext;
            int nms, oms;
            stp = mts ? 16'd2 : 16'd1;
            ext = (mrs == 4'h0);
            case (mrs)
                4'h0:    hit = mds ? mpend : !s2;
                4'hB:    hit = timer_req;
                4'hC:    hit = 1;
                4'hD:    hit = adc_req;
                default: hit = 0;
            endcase
            start = 0; setd = 0; oms = ms; odone = mdone; nms = 0;
            if (ms == 0) begin
                if (men && !mdone && mcnt != 0 && hit) begin nms = 1; start = 1; end
            end else if (ms == 1) begin
                nms = 2; mdata = msrc ^ 16'h5A3C;
            end else begin
                if (mcnt == 1) begin nms = 0; setd = 1; end
                else nms = (mtm && men) ? 1 : 0;
                msrc = msrc + stp; mdst = mdst + stp; mcnt = mcnt - 1;
            end
            fall  = s3 && !s2;
            mpend = (ext && mds) ? (fall || (mpend && !start)) : 0;
            s3 = s2; s2 = s1; s1 = ext_req_n;
            cwr = reg_wr && reg_sel == 2'd0;
            crd = reg_rd && reg_sel == 2'd0;
            if (reg_wr && oms != 2) begin
                if (reg_sel == 2'd1) msrc = reg_wdata;
                if (reg_sel == 2'd2) mdst = reg_wdata;
                if (reg_sel == 2'd3) mcnt = reg_wdata;
            end
            if (setd) mdone = 1;
            else if (cwr && marmed && !reg_wdata[4]) mdone = 0;
            if (cwr) begin
                if (reg_wdata[11:9] != 3'b111) mrs = reg_wdata[11:8];
                mam = reg_wdata[7]; mal = reg_wdata[6]; mds = reg_wdata[5];
                mie = reg_wdata[3]; mtm = reg_wdata[2]; mts = reg_wdata[1]; men = reg_wdata[0];
                marmed = 0;
            end else if (crd && odone) marmed = 1;
            ms = nms;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            bit ph;
            ph = (mrs == 4'h0) && (mam ? ms == 2 : ms == 1);
            chk("R4 bus_req", bus_req, ms != 0);
            chk("R3 bus_rd", bus_rd, ms == 1);
            chk("R3 bus_wr", bus_wr, ms == 2);
            chk("R3 bus_addr", bus_addr, (ms == 2) ? mdst : msrc);
            if (ms == 2) chk("R3 bus_wdata", bus_wdata, mdata);
            chk("R6 ack", ack, ph ^ mal);
            chk("R9 irq", irq, mdone && mie);
            chk("R7 ack non-capable", nc_ack, 0);
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk); reg_sel = sel; reg_wdata = d; reg_wr = 1;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] sel, input logic [15:0] exp);
        @(negedge clk); reg_sel = sel; reg_rd = 1; #1;
        chk(tag, reg_rdata, exp);
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ext(input int low_cycles);
        @(negedge clk); ext_req_n = 0;
        repeat (low_cycles) @(negedge clk);
        ext_req_n = 1;
        idle(8);
    endtask

    task automatic setup(input logic [15:0] s, input logic [15:0] d, input logic [15:0] c);
        wr(2'd1, s); wr(2'd2, d); wr(2'd3, c);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        #1;
        chk("R1 reset bus_req", bus_req, 0);
        chk("R1 reset ack", ack, 0);
        chk("R1 reset irq", irq, 0);
        @(negedge clk); rst_n = 1; cmp_on = 1;
        rd_chk("R1 reset ctrl", 2'd0, 16'h0000);

        // auto, cycle-steal, word, irq enabled
        setup(16'h0100, 16'h0200, 16'd3);
        wr(2'd0, 16'h0C0B);
        idle(20);
        rd_chk("R3 src after word units", 2'd1, 16'h0106);
        rd_chk("R3 dst after word units", 2'd2, 16'h0206);
        rd_chk("R3 count exhausted", 2'd3, 16'h0000);
        chk("R9 irq raised", irq, 1);

        // end flag handshake
        wr(2'd0, 16'h0C0A);
        chk("R8 unarmed write keeps flag", irq, 1);
        rd_chk("R8 flag visible", 2'd0, 16'h0C1A);
        wr(2'd0, 16'h0C0A);
        rd_chk("R8 armed write clears", 2'd0, 16'h0C0A);
        chk("R9 irq dropped", irq, 0);
        wr(2'd0, 16'h0C1A);
        rd_chk("R8 write of one ignored", 2'd0, 16'h0C0A);

        // auto burst, byte, irq disabled
        setup(16'h0300, 16'h0400, 16'd4);
        wr(2'd0, 16'h0C05);
        idle(20);
        rd_chk("R3 byte step", 2'd1, 16'h0304);
        chk("R9 irq gated", irq, 0);
        rd_chk("R8 burst end flag", 2'd0, 16'h0C15);
        wr(2'd0, 16'h0C04);

        // halt mid-burst
        setup(16'h0500, 16'h0600, 16'd10);
        wr(2'd0, 16'h0C05);
        idle(5);
        wr(2'd0, 16'h0C04);
        idle(10);
        chk("R10 bus released after halt", bus_req, 0);
        rd_chk("R10 remaining count", 2'd3, mcnt);
        chk("R10 count left non-zero", mcnt != 0, 1);

        // external level, ack in read cycle, active high
        setup(16'h0700, 16'h0800, 16'd2);
        wr(2'd0, 16'h0003);
        @(negedge clk); ext_req_n = 0;
        idle(20);
        ext_req_n = 1;
        rd_chk("R5 level request drained count", 2'd3, 16'h0000);
        rd_chk("R8 level end flag", 2'd0, 16'h0013);
        wr(2'd0, 16'h0002);

        // external edge, ack in write cycle, active low
        setup(16'h0900, 16'h0A00, 16'd3);
        wr(2'd0, 16'h00E1);
        idle(4);
        pulse_ext(3);
        rd_chk("R5 one edge one unit", 2'd3, 16'd2);
        pulse_ext(25);
        rd_chk("R5 long low still one unit", 2'd3, 16'd1);
        pulse_ext(2);
        rd_chk("R5 final edge", 2'd3, 16'd0);
        rd_chk("R6 ctrl with ack bits", 2'd0, 16'h00F1);
        wr(2'd0, 16'h0000);

        // timer and A/D sources
        setup(16'h0B00, 16'h0C00, 16'd1);
        wr(2'd0, 16'h0B01);
        @(negedge clk); adc_req = 1; @(negedge clk); adc_req = 0;
        idle(5);
        rd_chk("R2 wrong source ignored", 2'd3, 16'd1);
        @(negedge clk); timer_req = 1; @(negedge clk); timer_req = 0;
        idle(5);
        rd_chk("R2 timer request", 2'd3, 16'd0);
        rd_chk("R8 timer end flag", 2'd0, 16'h0B11);
        wr(2'd0, 16'h0B00);
        wr(2'd3, 16'd1);
        wr(2'd0, 16'h0D01);
        @(negedge clk); adc_req = 1; @(negedge clk); adc_req = 0;
        idle(5);
        rd_chk("R2 adc request", 2'd3, 16'd0);
        rd_chk("R8 adc end flag", 2'd0, 16'h0D11);
        wr(2'd0, 16'h0D00);

        // reserved source codes
        wr(2'd0, 16'h0E00);
        rd_chk("R2 reserved 1110 rejected", 2'd0, 16'h0D00);
        wr(2'd0, 16'h0F04);
        rd_chk("R2 reserved 1111 rejected", 2'd0, 16'h0D04);

        // zero count does not start
        wr(2'd3, 16'd0);
        wr(2'd0, 16'h0C01);
        idle(8);
        chk("R10 zero count idle", bus_req, 0);
        rd_chk("R10 zero count no flag", 2'd0, 16'h0C01);

        // non-capable instance masks external bits
        wr(2'd0, 16'h00E0);
        @(negedge clk); reg_sel = 2'd0; reg_rd = 1; #1;
        chk("R7 non-capable ctrl readback", rdata_nc, 16'h0000);
        chk("R6 capable ctrl readback", reg_rdata, 16'h00E0);
        @(negedge clk); reg_rd = 0;
        idle(3);

        cmp_on = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule